// File: doc/BRIEF.md
# Collision Retry and Backoff Controller

This block decides when a transmitter on a shared, collision-sensing line may try again after its frame has collided. The transmitter tells it when a frame attempt starts, whether the line is in the preamble/start-flag phase or the data phase, when a collision is seen, and when a frame completes. The block then asks for a jam sequence, waits out a backoff measured in slot times, and waits for one interframe gap of quiet line before it raises its retry permission again. After eight collisions on the same frame it gives up with a one-cycle abort pulse. Two registers stay visible on output ports: the collision-count register and the backoff down-counter.

Two backoff policies exist. In random mode each collision shifts a one into the collision-count register from the right, and the backoff preload is a free-running LFSR value masked by that register, so the window doubles with every collision. In slot mode every station owns a 6-bit slot number and the highest slot in use on the network is loaded into the collision-count register. The station then waits (highest slot − own slot) slot times, so slot 63 goes first and slot 1 goes last.

The controller is one state machine. ST_IDLE goes to ST_SEND on `tx_start`. ST_SEND goes to ST_HOLD on a collision in the preamble, to ST_JAM on a collision in the data phase, and back to ST_IDLE on `tx_done`. ST_HOLD goes to ST_JAM when the preamble ends. At the end of the jam, ST_JAM goes to ST_ABORT if the attempt budget is spent, to ST_DEFER if the preload is zero, and otherwise to ST_BACKOFF. ST_BACKOFF goes to ST_DEFER when the counter expires. ST_DEFER goes to ST_IDLE after the interframe gap. ST_ABORT goes to ST_IDLE after one cycle.

Top module: `cd_backoff_ctrl`

## Requirements
- R1: After reset, `retry_en` is 1, and `jam_req`, `bko_active`, `abort_pulse`, `coll_cnt` and `bko_cnt` are all 0.
- R2: Suppose that while sending, `coll` is 1 with `in_data` 1 and `in_pre` 0. Then `jam_req` is 1 from the next cycle for exactly JAM_LEN cycles.
- R3: A collision with `in_pre` 1 produces no jam while `in_pre` stays 1. The jam starts in the first cycle after the cycle in which `in_pre` is seen low.
- R4: With `cfg_jam_type` 0, `jam_bit` alternates 1,0,1,… starting with 1 in the first jam cycle. With `cfg_jam_type` 1, `jam_bit` is 0 for the whole jam.
- R5: In random mode (`cfg_det_mode` 0), the n-th collision of a frame leaves `coll_cnt` equal to 2^n − 1, a one shifted in at bit 0.
- R6: In random mode, the backoff preload has no bit set outside the bits set in `coll_cnt`.
- R7: `bko_cnt` is loaded with the preload when the jam ends and decrements once every SLOT_CYC cycles. `bko_active` stays 1 for exactly preload × SLOT_CYC cycles, and for none if the preload is 0.
- R8: In slot mode, a collision loads `cfg_max_slot` into `coll_cnt`. The preload is `cfg_max_slot` − `cfg_my_slot`, or 0 when `cfg_my_slot` ≥ `cfg_max_slot`.
- R9: After backoff, `retry_en` returns only after IFS_CYC consecutive cycles with `line_idle` 1. A busy cycle restarts that count.
- R10: On the MAX_TRY-th (8th) collision of a frame, the cycle after the jam has `abort_pulse` 1 for exactly one cycle. After that, `coll_cnt` is 0 and `retry_en` is 1.
- R11: `tx_done` while sending returns to idle and clears `coll_cnt` and the attempt count.
- R12: `coll` has no effect when idle, or while sending with both `in_pre` and `in_data` 0.
- R13: At most one of `jam_req`, `bko_active`, `retry_en` and `abort_pulse` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_det_mode | input | 1 | 1 = slot mode, 0 = random mode |
| cfg_jam_type | input | 1 | 0 = alternating jam, 1 = constant-low jam |
| cfg_my_slot | input | SW | This station's slot number |
| cfg_max_slot | input | SW | Highest slot number in use on the network |
| tx_start | input | 1 | Transmitter begins a frame attempt |
| in_pre | input | 1 | Transmitter is in preamble / start flag |
| in_data | input | 1 | Transmitter is in the data phase |
| coll | input | 1 | Collision detected |
| tx_done | input | 1 | Frame finished without collision |
| line_idle | input | 1 | Line sensed idle |
| jam_req | output | 1 | Transmitter must send jam |
| jam_bit | output | 1 | Jam level for the current cycle |
| bko_active | output | 1 | Backoff counting in progress |
| retry_en | output | 1 | Transmitter may start an attempt |
| abort_pulse | output | 1 | Retries exhausted, frame dropped |
| coll_cnt | output | CW | Collision-count register |
| bko_cnt | output | CW | Backoff down-counter |

## Verification
A wrong state or count in this block shows up at the ports within one jam plus one backoff. A bad shift or load in the collision register appears on `coll_cnt` right after the jam, and in random mode it also changes which preload bits may be set. A slot-timer fault changes the length of the `bko_active` window by a multiple of SLOT_CYC cycles. Faults in the jam or gap counters move the falling edge of `jam_req` or the rising edge of `retry_en` by whole cycles. An attempt-count fault moves the abort pulse to a different collision.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_HOLD,
        ST_JAM,
        ST_BACKOFF,
        ST_DEFER,
        ST_ABORT
    } cdb_state_e;
endpackage

// File: rtl/cdb_lfsr.sv
module cdb_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] q
);
    // Galois form, shifting right, free-running from a nonzero seed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= W'(1);
        else
            q <= {1'b0, q[W-1:1]} ^ (q[0] ? TAPS : '0);
    end
endmodule

// File: rtl/cdb_coll_reg.sv
module cdb_coll_reg #(
    parameter int CW = 8,
    parameter int SW = 6,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic          clear,
    input  logic          det_mode,
    input  logic [SW-1:0] max_slot,
    output logic [CW-1:0] cnt,
    output logic [TW-1:0] tries
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            tries <= '0;
        end else if (clear) begin
            cnt   <= '0;
            tries <= '0;
        end else if (hit) begin
            tries <= tries + 1'b1;
            if (det_mode)
                cnt <= CW'(max_slot);
            else
                cnt <= {cnt[CW-2:0], 1'b1};
        end
    end
endmodule

// File: rtl/cdb_slot_timer.sv
module cdb_slot_timer #(
    parameter int CW       = 8,
    parameter int SLOT_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] preload,
    input  logic          run,
    output logic [CW-1:0] cnt,
    output logic          last
);
    localparam int PW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam logic [PW-1:0] PRE_END = PW'(SLOT_CYC - 1);

    logic [PW-1:0] pre;
    logic          slot_end;

    assign slot_end = run && (pre == PRE_END);
    assign last     = slot_end && (cnt == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            pre <= '0;
        end else if (load) begin
            cnt <= preload;
            pre <= '0;
        end else if (slot_end) begin
            cnt <= cnt - 1'b1;
            pre <= '0;
        end else if (run) begin
            pre <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/cd_backoff_ctrl.sv
module cd_backoff_ctrl
    import cdb_pkg::*;
#(
    parameter int CW       = 8,
    parameter int SW       = 6,
    parameter int SLOT_CYC = 4,
    parameter int JAM_LEN  = 4,
    parameter int IFS_CYC  = 6,
    parameter int MAX_TRY  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_det_mode,
    input  logic          cfg_jam_type,
    input  logic [SW-1:0] cfg_my_slot,
    input  logic [SW-1:0] cfg_max_slot,
    input  logic          tx_start,
    input  logic          in_pre,
    input  logic          in_data,
    input  logic          coll,
    input  logic          tx_done,
    input  logic          line_idle,
    output logic          jam_req,
    output logic          jam_bit,
    output logic          bko_active,
    output logic          retry_en,
    output logic          abort_pulse,
    output logic [CW-1:0] coll_cnt,
    output logic [CW-1:0] bko_cnt
);
    localparam int TW = $clog2(MAX_TRY + 1);
    localparam int JW = (JAM_LEN > 1) ? $clog2(JAM_LEN) : 1;
    localparam int IW = (IFS_CYC > 1) ? $clog2(IFS_CYC) : 1;
    localparam logic [JW-1:0] JAM_END = JW'(JAM_LEN - 1);
    localparam logic [IW-1:0] IFS_END = IW'(IFS_CYC - 1);
    localparam logic [TW-1:0] TRY_LIM = TW'(MAX_TRY);

    cdb_state_e    state, nxt;
    logic [JW-1:0] jc;
    logic [IW-1:0] ic;
    logic [TW-1:0] tries;
    logic [CW-1:0] rnd;
    logic [CW-1:0] preload;
    logic [SW:0]   slot_gap;
    logic          hit, clear, jam_end, bko_last;

    // ---------------- shared datapath ----------------
    assign hit     = (state == ST_SEND) && coll && (in_pre || in_data);
    assign clear   = ((state == ST_SEND) && tx_done && !hit) || (state == ST_ABORT);
    assign jam_end = (state == ST_JAM) && (jc == JAM_END);

    assign slot_gap = {1'b0, cfg_max_slot} - {1'b0, cfg_my_slot};

    always_comb begin
        if (cfg_det_mode)
            preload = slot_gap[SW] ? '0 : CW'(slot_gap[SW-1:0]);
        else
            preload = rnd & coll_cnt;
    end

    cdb_lfsr #(.W(CW)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .q     (rnd)
    );

    cdb_coll_reg #(.CW(CW), .SW(SW), .TW(TW)) u_coll (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .clear    (clear),
        .det_mode (cfg_det_mode),
        .max_slot (cfg_max_slot),
        .cnt      (coll_cnt),
        .tries    (tries)
    );

    cdb_slot_timer #(.CW(CW), .SLOT_CYC(SLOT_CYC)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (jam_end),
        .preload (preload),
        .run     (state == ST_BACKOFF),
        .cnt     (bko_cnt),
        .last    (bko_last)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (tx_start) nxt = ST_SEND;
            ST_SEND: begin
                if (coll && in_pre)       nxt = ST_HOLD;
                else if (coll && in_data) nxt = ST_JAM;
                else if (tx_done)         nxt = ST_IDLE;
            end
            ST_HOLD:    if (!in_pre) nxt = ST_JAM;
            ST_JAM: begin
                if (jam_end) begin
                    if (tries == TRY_LIM)   nxt = ST_ABORT;
                    else if (preload == '0) nxt = ST_DEFER;
                    else                    nxt = ST_BACKOFF;
                end
            end
            ST_BACKOFF: if (bko_last) nxt = ST_DEFER;
            ST_DEFER:   if (line_idle && (ic == IFS_END)) nxt = ST_IDLE;
            ST_ABORT:   nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // ---------------- phase counters ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            jc <= '0;
            ic <= '0;
        end else begin
            jc <= (state == ST_JAM && !jam_end) ? jc + 1'b1 : '0;
            if (state != ST_DEFER || !line_idle || ic == IFS_END)
                ic <= '0;
            else
                ic <= ic + 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        jam_req     = 1'b0;
        jam_bit     = 1'b0;
        bko_active  = 1'b0;
        retry_en    = 1'b0;
        abort_pulse = 1'b0;
        unique case (state)
            ST_IDLE:    retry_en = 1'b1;
            ST_JAM: begin
                jam_req = 1'b1;
                jam_bit = !cfg_jam_type && !jc[0];
            end
            ST_BACKOFF: bko_active = 1'b1;
            ST_ABORT:   abort_pulse = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/cdb_backoff_chk.sv
module cdb_backoff_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_det_mode,
    input logic          in_pre,
    input logic          jam_req,
    input logic          bko_active,
    input logic          retry_en,
    input logic          abort_pulse,
    input logic [CW-1:0] coll_cnt,
    input logic [CW-1:0] bko_cnt
);
    a_r13_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({jam_req, bko_active, retry_en, abort_pulse}));

    a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> (coll_cnt == '0 && retry_en));

    a_r10_abort_after_jam: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> $past(jam_req));

    a_r7_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (bko_active && $past(bko_active)) |-> (bko_cnt <= $past(bko_cnt)));

    a_r6_preload_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bko_active) && !cfg_det_mode) |-> ((bko_cnt & ~coll_cnt) == '0));

    a_r5_fill_from_right: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_det_mode |-> (((coll_cnt + 1'b1) & coll_cnt) == '0));

    a_r3_jam_after_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jam_req) |-> !$past(in_pre));
endmodule

bind cd_backoff_ctrl cdb_backoff_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_det_mode (cfg_det_mode),
    .in_pre       (in_pre),
    .jam_req      (jam_req),
    .bko_active   (bko_active),
    .retry_en     (retry_en),
    .abort_pulse  (abort_pulse),
    .coll_cnt     (coll_cnt),
    .bko_cnt      (bko_cnt)
);

// File: tb/tb_cd_backoff_ctrl.sv
module tb_cd_backoff_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8, SW = 6, SLOT_CYC = 4, JAM_LEN = 4, IFS_CYC = 6, MAX_TRY = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_det_mode = 1'b0, cfg_jam_type = 1'b0;
    logic [SW-1:0] cfg_my_slot = '0, cfg_max_slot = '0;
    logic tx_start = 1'b0, in_pre = 1'b0, in_data = 1'b0, coll = 1'b0, tx_done = 1'b0;
    logic line_idle = 1'b1;
    logic jam_req, jam_bit, bko_active, retry_en, abort_pulse;
    logic [CW-1:0] coll_cnt, bko_cnt;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cd_backoff_ctrl #(.CW(CW), .SW(SW), .SLOT_CYC(SLOT_CYC), .JAM_LEN(JAM_LEN),
                      .IFS_CYC(IFS_CYC), .MAX_TRY(MAX_TRY)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_det_mode(cfg_det_mode), .cfg_jam_type(cfg_jam_type),
        .cfg_my_slot(cfg_my_slot), .cfg_max_slot(cfg_max_slot), .tx_start(tx_start),
        .in_pre(in_pre), .in_data(in_data), .coll(coll), .tx_done(tx_done),
        .line_idle(line_idle), .jam_req(jam_req), .jam_bit(jam_bit),
        .bko_active(bko_active), .retry_en(retry_en), .abort_pulse(abort_pulse),
        .coll_cnt(coll_cnt), .bko_cnt(bko_cnt));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One frame attempt that collides; returns after the jam, at the first non-jam cycle
    task automatic collide(input bit during_pre, input int pre_left);
        tx_start = 1'b1; in_pre = 1'b1; in_data = 1'b0;
        @(negedge clk);
        tx_start = 1'b0;
        check(retry_en == 1'b0, "R13 retry low while sending", int'(retry_en), 0);
        if (during_pre) begin
            coll = 1'b1;
            @(negedge clk);
            coll = 1'b0;
            for (int i = 0; i < pre_left; i++) begin
                check(jam_req == 1'b0, "R3 no jam inside preamble", int'(jam_req), 0);
                @(negedge clk);
            end
            in_pre = 1'b0; in_data = 1'b1;
            @(negedge clk);
            check(jam_req == 1'b1, "R3 jam right after preamble", int'(jam_req), 1);
        end else begin
            in_pre = 1'b0; in_data = 1'b1; coll = 1'b1;
            @(negedge clk);
            coll = 1'b0;
            check(jam_req == 1'b1, "R2 jam next cycle", int'(jam_req), 1);
        end
        for (int i = 0; i < JAM_LEN; i++) begin
            check(jam_req == 1'b1, "R2 jam length", int'(jam_req), 1);
            check(jam_bit == ((!cfg_jam_type) && (i % 2 == 0)), "R4 jam pattern",
                  int'(jam_bit), int'((!cfg_jam_type) && (i % 2 == 0)));
            @(negedge clk);
        end
        in_data = 1'b0;
        check(jam_req == 1'b0, "R2 jam ends", int'(jam_req), 0);
    endtask

    task automatic backoff_len(output int p, output int len);
        p = bko_active ? int'(bko_cnt) : 0;
        len = 0;
        while (bko_active && len < 100000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic defer_len(output int len);
        len = 0;
        while (!retry_en && len < 100000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic succeed();
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0; tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        check(retry_en == 1'b1, "R11 idle after success", int'(retry_en), 1);
        check(coll_cnt == '0, "R11 count cleared", int'(coll_cnt), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int p, len, dl;
        do_reset();
        // R1 reset state
        check(retry_en == 1'b1 && jam_req == 1'b0 && bko_active == 1'b0 && abort_pulse == 1'b0,
              "R1 reset outputs", int'({retry_en, jam_req, bko_active, abort_pulse}), 8);
        check(coll_cnt == '0 && bko_cnt == '0, "R1 reset counters", int'(coll_cnt) + int'(bko_cnt), 0);

        // R12 collision when idle is ignored
        coll = 1'b1; @(negedge clk); coll = 1'b0;
        check(jam_req == 1'b0 && retry_en == 1'b1, "R12 idle collision ignored", int'(jam_req), 0);
        check(coll_cnt == '0, "R12 count unchanged", int'(coll_cnt), 0);
        // R12 collision outside preamble/data ignored
        tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
        coll = 1'b1; @(negedge clk); coll = 1'b0;
        check(jam_req == 1'b0 && coll_cnt == '0, "R12 gap collision ignored", int'(jam_req), 0);
        tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
        check(retry_en == 1'b1, "R11 done returns idle", int'(retry_en), 1);

        // Random mode: eight collisions on one frame
        for (int n = 1; n <= MAX_TRY; n++) begin
            collide(n % 2 == 0, n % 3);
            if (n < MAX_TRY) begin
                check(int'(coll_cnt) == (1 << n) - 1, "R5 ones from right", int'(coll_cnt), (1 << n) - 1);
                check((bko_cnt & ~coll_cnt) == '0 || !bko_active, "R6 preload within mask",
                      int'(bko_cnt), int'(bko_cnt & coll_cnt));
                backoff_len(p, len);
                check(len == p * SLOT_CYC, "R7 backoff duration", len, p * SLOT_CYC);
                defer_len(dl);
                check(dl == IFS_CYC, "R9 interframe gap", dl, IFS_CYC);
            end else begin
                check(abort_pulse == 1'b1 && bko_active == 1'b0, "R10 abort after last jam",
                      int'(abort_pulse), 1);
                @(negedge clk);
                check(abort_pulse == 1'b0 && retry_en == 1'b1, "R10 one-cycle abort", int'(abort_pulse), 0);
                check(coll_cnt == '0, "R10 count cleared", int'(coll_cnt), 0);
            end
        end

        // Random mode, constant jam, three collisions then success
        cfg_jam_type = 1'b1;
        for (int n = 1; n <= 3; n++) begin
            collide(n == 2, 2);
            check(int'(coll_cnt) == (1 << n) - 1, "R5 second frame", int'(coll_cnt), (1 << n) - 1);
            backoff_len(p, len);
            check(len == p * SLOT_CYC, "R7 backoff duration", len, p * SLOT_CYC);
            defer_len(dl);
            check(dl == IFS_CYC, "R9 interframe gap", dl, IFS_CYC);
        end
        succeed();
        cfg_jam_type = 1'b0;

        // Slot mode sweep
        cfg_det_mode = 1'b1; cfg_max_slot = 6'd63;
        do_reset();
        for (int s = 1; s <= 63; s++) begin
            cfg_my_slot = SW'(s);
            collide(s % 4 == 0, 1);
            check(int'(coll_cnt) == 63, "R8 max slot loaded", int'(coll_cnt), 63);
            backoff_len(p, len);
            check(p == 63 - s, "R8 slot preload", p, 63 - s);
            check(len == (63 - s) * SLOT_CYC, "R7 slot backoff duration", len, (63 - s) * SLOT_CYC);
            defer_len(dl);
            check(dl == IFS_CYC, "R9 interframe gap", dl, IFS_CYC);
            succeed();
        end

        // Own slot above max: zero preload, no backoff
        cfg_max_slot = 6'd20; cfg_my_slot = 6'd30;
        collide(1'b0, 0);
        check(bko_active == 1'b0, "R8 own slot above max gives zero", int'(bko_active), 0);
        check(bko_cnt == '0, "R7 zero preload", int'(bko_cnt), 0);
        defer_len(dl);
        check(dl == IFS_CYC, "R9 gap after zero backoff", dl, IFS_CYC);
        succeed();

        // Busy line restarts the gap count
        cfg_my_slot = 6'd20;
        collide(1'b0, 0);
        for (int i = 0; i < 3; i++) begin
            check(retry_en == 1'b0, "R9 waiting gap", int'(retry_en), 0);
            @(negedge clk);
        end
        line_idle = 1'b0;
        repeat (5) @(negedge clk);
        check(retry_en == 1'b0, "R9 busy holds off", int'(retry_en), 0);
        line_idle = 1'b1;
        defer_len(dl);
        check(dl == IFS_CYC, "R9 gap restarts after busy", dl, IFS_CYC);
        succeed();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule